// File: doc/BRIEF.md
# Multi-Mode ADC Conversion Sequencer

This block controls an eight-way analog multiplexer and a successive-approximation converter core. The converter is modelled as a simple handshake: the sequencer pulses a start line with a channel number on the mux select, and the core later pulses a done line with a result. Software programs a first channel, a last channel, an operating mode and a resolution through a small register interface, then launches a run with a start bit.

Four modes are available. Single mode converts the first channel once. Scan mode walks the channels once, from the first channel up to the last. Continuous mode keeps walking that range until software stops it. Triggered-repeat mode walks the range once and then holds, waiting for a fresh start bit, for as long as it is not stopped. Each result is written to a data register tagged with its channel, and an interrupt flag is raised. A result that replaces one nobody has read sets a sticky overrun bit. A pause bit holds off new conversion starts without abandoning the run.

Top module: `adc_sequencer`

## Requirements
- R1: After reset, busy, irq, convStart, the status register (address 1) and the data register (address 2) are all zero.
- R2: Single mode (mode code 0) converts only the first channel, once. Busy falls in the cycle after that result is captured.
- R3: Scan mode (mode code 1) converts each channel once, in ascending order from the first channel to the last, and then goes idle with busy low.
- R4: When the first channel is greater than the last, the walk continues from channel 7 back to channel 0.
- R5: Continuous mode (mode code 2) restarts the range from the first channel after each pass. A write with the stop bit returns the block to idle, and no further conversion starts after that.
- R6: Triggered-repeat mode (mode code 3) converts the range once and then holds with busy high and no conversion start. Each later start write runs one more pass, and the stop bit ends the mode.
- R7: The data register (address 2) holds the result in bits [9:0] and the channel in bits [12:10]. In 10-bit mode (control bit 8 set) the full converter value is stored. In 8-bit mode the top eight converter bits are stored in bits [7:0], and bits [9:8] read zero.
- R8: Each captured result sets irq (status bit 1). Writing 1 to status bit 1 clears it. If a capture and a clear land in the same cycle, irq ends up set.
- R9: A capture while the previous result is still unread sets overrun (status bit 2). Reading address 2 marks the result as read, and a read in the same cycle as a capture does not cause an overrun. Writing 1 to status bit 2 clears overrun.
- R10: While the pause bit (control bit 11, a stored level) is set, no conversion start is issued and busy stays high. Clearing it lets the run continue.
- R11: convStart is a one-cycle pulse, and no further pulse follows until the converter has returned done.
- R12: Control register (address 0) layout: first channel in [2:0], last channel in [5:3], mode in [7:6], resolution in [8], start in [9] and stop in [10], both write-only strobes, and pause in [11]. Status bit 0 is busy, and status bit 3 reflects pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; has a side effect only at address 2 |
| addr | input | 2 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the current address, combinational |
| convStart | output | 1 | Start pulse to the converter core |
| convCh | output | 3 | Multiplexer channel select |
| convDone | input | 1 | Conversion finished pulse from the core |
| convResult | input | 10 | Converter result, valid with convDone |
| busy | output | 1 | Sequencer is active |
| irq | output | 1 | Result-ready interrupt flag |

## Verification
Two events can land in the same clock edge: the hardware capture of a result, and a software access to the flags. In one case that access is the write that clears irq. In the other it is the read of the data register that marks the previous result as consumed. The bench's converter model drives the status-clear write, or the data read, in exactly the cycle in which it asserts done. Afterwards irq must still be set, and overrun must stay clear when the read coincided with the capture. A later capture with no read in between must then set overrun.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_SCAN   = 2'd1,
    MODE_CONT   = 2'd2,
    MODE_TRIG   = 2'd3
  } seqMode_t;

  // register-side commands toward the control
  typedef struct packed {
    logic     start;
    logic     stop;
    logic     pause;
    logic     wide;
    seqMode_t mode;
  } seqCmd_t;

  // control strobes toward the datapath
  typedef struct packed {
    logic capture;
    logic busy;
    logic wide;
  } seqStrobe_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqCmd_t         cmd,
  input  logic [CH_W-1:0] firstCh,
  input  logic [CH_W-1:0] lastCh,
  input  logic            convDone,
  output logic            convStart,
  output logic [CH_W-1:0] convCh,
  output seqStrobe_t      strb
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_CONV, S_HOLD} state_t;

  localparam logic [CH_W-1:0] TOP_CH = CH_W'(NUM_CH - 1);

  state_t          state;
  logic [CH_W-1:0] ch, firstR, lastR, nextCh;
  seqMode_t        modeR;
  logic            wideR, lastOne, canStart;

  assign canStart = (state == S_IDLE) || (state == S_HOLD);
  assign lastOne  = (modeR == MODE_SINGLE) || (ch == lastR);
  assign nextCh   = (ch == TOP_CH) ? '0 : ch + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      ch     <= '0;
      firstR <= '0;
      lastR  <= '0;
      modeR  <= MODE_SINGLE;
      wideR  <= 1'b0;
    end else if (cmd.stop) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE, S_HOLD: if (cmd.start) begin
          firstR <= firstCh;
          lastR  <= lastCh;
          modeR  <= cmd.mode;
          wideR  <= cmd.wide;
          ch     <= firstCh;
          state  <= S_ISSUE;
        end
        S_ISSUE: if (!cmd.pause) state <= S_CONV;
        S_CONV: if (convDone) begin
          if (lastOne) begin
            unique case (modeR)
              MODE_CONT: begin ch <= firstR; state <= S_ISSUE; end
              MODE_TRIG: state <= S_HOLD;
              default:   state <= S_IDLE;
            endcase
          end else begin
            ch    <= nextCh;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign convStart    = (state == S_ISSUE) && !cmd.pause && !cmd.stop;
  assign convCh       = ch;
  assign strb.capture = (state == S_CONV) && convDone && !cmd.stop;
  assign strb.busy    = (state != S_IDLE);
  assign strb.wide    = wideR;

  // R11: one start pulse per conversion
  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CONV && !convDone) |-> !convStart);
  // R10: pause holds off starts
  a_r10_pause_blocks: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pause |-> !convStart);
  // R2: single mode ends after its one result
  a_r2_single_ends: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && modeR == MODE_SINGLE) |=> !strb.busy);
  // R3: scan ends after the last channel
  a_r3_scan_ends: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && modeR == MODE_SCAN && ch == lastR) |=> !strb.busy);
  // R6: holding state issues nothing until a new start
  a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && !cmd.start) |=> !convStart);
  // R5: stop returns to idle
  a_r5_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stop |=> !strb.busy);

endmodule

// File: rtl/adc_seq_data.sv
module adc_seq_data
  import adc_seq_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int RES_W  = 10,
  parameter int LOW_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [RES_W-1:0]  convResult,
  input  logic [CH_W-1:0]   convCh,
  input  seqStrobe_t        strb,
  output seqCmd_t           cmd,
  output logic [CH_W-1:0]   firstCh,
  output logic [CH_W-1:0]   lastCh,
  output logic              irq
);

  // control word layout
  localparam int LAST_LO   = CH_W;
  localparam int MODE_LO   = 2 * CH_W;
  localparam int WIDE_BIT  = MODE_LO + 2;
  localparam int START_BIT = WIDE_BIT + 1;
  localparam int STOP_BIT  = WIDE_BIT + 2;
  localparam int PAUSE_BIT = WIDE_BIT + 3;
  localparam int TAG_LO    = RES_W;

  logic             ctrlWr, statWr, dataRd;
  logic             pauseR, irqR, ovrR, unreadR;
  logic [RES_W-1:0] resultR, shaped;
  logic [CH_W-1:0]  tagR;

  assign ctrlWr = wrEn && (addr == ADDR_W'(0));
  assign statWr = wrEn && (addr == ADDR_W'(1));
  assign dataRd = rdEn && (addr == ADDR_W'(2));

  assign cmd.start = ctrlWr && wrData[START_BIT];
  assign cmd.stop  = ctrlWr && wrData[STOP_BIT];
  assign cmd.pause = pauseR;
  assign cmd.wide  = wrData[WIDE_BIT];
  assign cmd.mode  = seqMode_t'(wrData[MODE_LO +: 2]);
  assign firstCh   = wrData[CH_W-1:0];
  assign lastCh    = wrData[LAST_LO +: CH_W];

  assign shaped = strb.wide ? convResult
                            : RES_W'(convResult[RES_W-1 -: LOW_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseR  <= 1'b0;
      irqR    <= 1'b0;
      ovrR    <= 1'b0;
      unreadR <= 1'b0;
      resultR <= '0;
      tagR    <= '0;
    end else begin
      if (ctrlWr) pauseR <= wrData[PAUSE_BIT];
      if (strb.capture) begin
        resultR <= shaped;
        tagR    <= convCh;
      end
      if (strb.capture)              irqR <= 1'b1;
      else if (statWr && wrData[1])  irqR <= 1'b0;
      if (strb.capture)              unreadR <= 1'b1;
      else if (dataRd)               unreadR <= 1'b0;
      if (strb.capture && unreadR && !dataRd) ovrR <= 1'b1;
      else if (statWr && wrData[2])           ovrR <= 1'b0;
    end
  end

  assign irq = irqR;

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_W'(0): rdData[PAUSE_BIT] = pauseR;
      ADDR_W'(1): rdData[3:0] = {pauseR, ovrR, irqR, strb.busy};
      ADDR_W'(2): begin
        rdData[RES_W-1:0]       = resultR;
        rdData[TAG_LO +: CH_W]  = tagR;
      end
      default: rdData = '0;
    endcase
  end

  // R8: every capture leaves irq set, even against a clear
  a_r8_irq_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> irq);
  // R9: unread result overwritten raises overrun
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && unreadR && !dataRd) |=> ovrR);
  a_r9_read_no_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !ovrR && (!unreadR || dataRd)) |=> !ovrR);
  // R7: narrow results leave the upper bits clear
  a_r7_narrow_top: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && !strb.wide) |=> (resultR[RES_W-1:LOW_W] == '0));

endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int LOW_W  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              convStart,
  output logic [CH_W-1:0]   convCh,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              busy,
  output logic              irq
);

  seqCmd_t         cmd;
  seqStrobe_t      strb;
  logic [CH_W-1:0] firstCh, lastCh;

  adc_seq_data #(
    .CH_W(CH_W), .RES_W(RES_W), .LOW_W(LOW_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) uData (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .convResult(convResult),
    .convCh(convCh), .strb(strb), .cmd(cmd), .firstCh(firstCh),
    .lastCh(lastCh), .irq(irq)
  );

  adc_seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .firstCh(firstCh),
    .lastCh(lastCh), .convDone(convDone), .convStart(convStart),
    .convCh(convCh), .strb(strb)
  );

  assign busy = strb.busy;

endmodule

// File: tb/adc_sequencer_test.sv
module adc_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        drvWr = 1'b0, drvRd = 1'b0, mdlWr = 1'b0, mdlRd = 1'b0;
  logic [1:0]  drvAddr = '0, mdlAddr = '0;
  logic [15:0] drvData = '0, mdlData = '0;
  logic        wrEn, rdEn;
  logic [1:0]  addr;
  logic [15:0] wrData, rdData;
  logic        convStart, convDone = 1'b0, busy, irq;
  logic [2:0]  convCh;
  logic [9:0]  convResult = '0;

  int nChecks = 0, nFail = 0, startCount = 0, convNum = 0;
  int expCh[$];
  logic [9:0] lastRes = '0;
  logic [2:0] lastTag = '0;
  bit clrOnDone = 0, readOnDone = 0;
  string curReq = "R3";

  assign wrEn   = drvWr | mdlWr;
  assign rdEn   = drvRd | mdlRd;
  assign addr   = (mdlWr | mdlRd) ? mdlAddr : drvAddr;
  assign wrData = mdlWr ? mdlData : drvData;

  always #2.5 clk = ~clk;

  adc_sequencer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .convStart(convStart),
    .convCh(convCh), .convDone(convDone), .convResult(convResult),
    .busy(busy), .irq(irq)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model and scoreboard monitor
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (convDone) begin
        convDone = 1'b0; mdlWr = 1'b0; mdlRd = 1'b0;
      end
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          convNum++;
          convResult = 10'((lastTag * 37 + convNum * 91 + 5) % 1024);
          lastRes = convResult;
          convDone = 1'b1;
          if (clrOnDone) begin mdlWr = 1'b1; mdlAddr = 2'd1; mdlData = 16'h2; end
          if (readOnDone) begin mdlRd = 1'b1; mdlAddr = 2'd2; end
        end
      end
      if (convStart) begin
        startCount++;
        lastTag = convCh;
        cnt = 3;
        if (expCh.size() == 0) check(curReq, "unexpected convStart", 1, 0);
        else check(curReq, "channel order", convCh, expCh.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  function automatic logic [15:0] cw(int f, int l, int m, bit wide, bit st, bit sp, bit pa);
    return {4'b0, pa, sp, st, wide, 2'(m), 3'(l), 3'(f)};
  endfunction

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); drvWr = 1'b1; drvAddr = a; drvData = d;
    @(negedge clk); drvWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); drvRd = 1'b1; drvAddr = a; #1 d = rdData;
    @(negedge clk); drvRd = 1'b0;
  endtask

  task automatic waitIdle(string req);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    check(req, "busy dropped", busy, 0);
  endtask

  task automatic waitStarts(int target);
    int n = 0;
    while (startCount < target && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic push(int f, int l);
    int c = f;
    forever begin
      expCh.push_back(c);
      if (c == l) break;
      c = (c + 1) % 8;
    end
  endtask

  initial begin
    logic [15:0] v;
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "irq", irq, 0);
    check("R1", "convStart", convStart, 0);
    rd(2'd1, v); check("R1", "status", v, 0);
    rd(2'd2, v); check("R1", "data", v, 0);

    // R2 single, 10-bit, ignores last channel
    curReq = "R2"; expCh.push_back(5);
    wr(2'd0, cw(5, 7, 0, 1, 1, 0, 0));
    waitIdle("R2");
    check("R2", "queue drained", expCh.size(), 0);
    check("R8", "irq after capture", irq, 1);
    rd(2'd2, v); check("R7", "wide data", v, {3'b0, 3'd5, lastRes});
    wr(2'd1, 16'h2); check("R8", "irq cleared", irq, 0);
    rd(2'd1, v); check("R12", "status idle", v, 0);

    // R3 scan 2..5 in 8-bit mode
    curReq = "R3"; push(2, 5);
    wr(2'd0, cw(2, 5, 1, 0, 1, 0, 0));
    rd(2'd1, v); check("R12", "status busy bit", v[0], 1);
    waitIdle("R3");
    check("R3", "queue drained", expCh.size(), 0);
    rd(2'd2, v); check("R7", "narrow data", v, {3'b0, 3'd5, 2'b0, lastRes[9:2]});
    rd(2'd1, v); check("R9", "overrun set", v[2], 1);
    wr(2'd1, 16'h6); rd(2'd1, v); check("R9", "overrun cleared", v[2], 0);

    // R4 wrap 6..1
    curReq = "R4"; push(6, 1); base = startCount;
    wr(2'd0, cw(6, 1, 1, 1, 1, 0, 0));
    waitIdle("R4");
    check("R4", "conversions", startCount - base, 4);

    // R5 continuous 3..4
    curReq = "R5"; base = startCount;
    for (int i = 0; i < 3; i++) push(3, 4);
    wr(2'd0, cw(3, 4, 2, 1, 1, 0, 0));
    waitStarts(base + 6);
    wr(2'd0, cw(0, 0, 0, 0, 0, 1, 0));
    check("R5", "stopped idle", busy, 0);
    repeat (20) @(negedge clk);
    check("R5", "no starts after stop", startCount - base, 6);

    // R6 triggered repeat 0..1
    curReq = "R6"; base = startCount; push(0, 1);
    wr(2'd0, cw(0, 1, 3, 1, 1, 0, 0));
    waitStarts(base + 2);
    repeat (25) @(negedge clk);
    check("R6", "holding busy", busy, 1);
    check("R6", "held starts", startCount - base, 2);
    push(0, 1);
    wr(2'd0, cw(0, 1, 3, 1, 1, 0, 0));
    waitStarts(base + 4);
    repeat (25) @(negedge clk);
    check("R6", "second pass", startCount - base, 4);
    wr(2'd0, cw(0, 0, 0, 0, 0, 1, 0));
    check("R6", "stop ends mode", busy, 0);

    // R10 pause holds start
    curReq = "R10"; base = startCount; expCh.push_back(4);
    wr(2'd0, cw(4, 4, 0, 1, 1, 0, 1));
    repeat (20) @(negedge clk);
    check("R10", "no start while paused", startCount - base, 0);
    check("R10", "busy while paused", busy, 1);
    rd(2'd1, v); check("R12", "pause status", v[3], 1);
    wr(2'd0, cw(0, 0, 0, 0, 0, 0, 0));
    waitIdle("R10");
    check("R10", "resumed conversion", startCount - base, 1);

    // R8 collision: clear in the capture cycle
    wr(2'd1, 16'h6);
    curReq = "R8"; clrOnDone = 1; expCh.push_back(1);
    wr(2'd0, cw(1, 1, 0, 1, 1, 0, 0));
    waitIdle("R8"); clrOnDone = 0;
    check("R8", "set wins over clear", irq, 1);

    // R9 collision: read in the capture cycle
    wr(2'd1, 16'h6);
    curReq = "R9"; readOnDone = 1; expCh.push_back(2);
    wr(2'd0, cw(2, 2, 0, 1, 1, 0, 0));
    waitIdle("R9"); readOnDone = 0;
    rd(2'd1, v); check("R9", "no overrun on same-cycle read", v[2], 0);
    expCh.push_back(3);
    wr(2'd0, cw(3, 3, 0, 1, 1, 0, 0));
    waitIdle("R9");
    rd(2'd1, v); check("R9", "overrun on unread", v[2], 1);
    rd(2'd2, v); check("R7", "tag follows channel", v[12:10], 3);

    repeat (10) @(negedge clk);
    check("R11", "queue empty at end", expCh.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule